// File: doc/BRIEF.md
# Serial Port Register Bank with Baud Tick Generator

This block sits between a host bus and the shifting logic of an asynchronous serial port. It decodes a 3-bit register offset and turns host reads and writes into register updates, read data and one-cycle strobes. The strobes tell the transmitter that a byte was loaded, and tell the receiver that its byte or its status flags were read and may be cleared. A bank-select bit, the top bit of the line-control register, changes the meaning of offsets 0 and 1. With the bit clear, they reach the data buffers and the interrupt-enable register. With the bit set, they reach the low and high bytes of a 16-bit clock divisor.

The divisor drives a down-counter. The counter issues a one-cycle tick every `divisor` clock cycles, which is sixteen ticks per bit time for the transmitter and receiver. With a 1.8432 MHz clock, the divisors 384, 96, 48, 24, 12 and 6 give 300, 1200, 2400, 4800, 9600 and 19200 baud. A divisor of zero stops the tick. A write to either divisor byte restarts the count, so a new rate takes effect at once.

Read data is combinational from the offset. The strobes are combinational from the offset and the read or write enable, and are valid in the same cycle.

Top module: `serial_regbank`

## Requirements
- R1: After reset, the line-control register, the interrupt-enable register and the divisor are all zero, and `baud_tick` stays low.
- R2: Offset 3 holds the line-control register. All eight bits are writable, they read back unchanged, and they appear on `line_ctrl`.
- R3: With `line_ctrl[7]` = 0, a write to offset 0 pulses `tx_load` for that cycle with `tx_byte` equal to `wdata`. A read of offset 0 returns `rx_byte` and pulses `rx_take`.
- R4: With `line_ctrl[7]` = 0, offset 1 accesses the interrupt-enable register. Only its low IER_W bits (4 by default) are stored, and the upper bits read as 0.
- R5: With `line_ctrl[7]` = 1, offset 0 reads and writes divisor bits 7:0, and offset 1 reads and writes divisor bits 15:8. In this bank, `tx_load` and `rx_take` stay low and the interrupt-enable register does not change.
- R6: A read of offset 5 returns `line_stat` and pulses `stat_take`. Writes to offset 5 have no effect.
- R7: With a non-zero divisor N and no divisor writes, `baud_tick` is high for exactly one cycle out of every N.
- R8: A divisor of 0 keeps `baud_tick` low.
- R9: Number the clock cycle that starts at the edge of a divisor-byte write as cycle 1. The first tick after the write falls in cycle N, where N is the new divisor, and later ticks follow every N cycles. This also holds when the write falls in a tick cycle.
- R10: Offsets 2, 4, 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rx_byte | input | 8 | Byte held by the receiver |
| line_stat | input | 8 | Status byte from the serialisers |
| tx_load | output | 1 | Transmit byte load strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_take | output | 1 | Receive buffer read strobe, clears data-ready |
| stat_take | output | 1 | Status read strobe, clears error flags |
| line_ctrl | output | 8 | Line-control register contents |
| int_enable | output | 4 | Interrupt-enable register contents |
| baud_tick | output | 1 | 16x baud tick |

## Verification
A divisor write and a counter wrap can land in the same cycle. The bench waits for a tick, drives a divisor-byte write while that tick is still high, and confirms the tick is present in that cycle. It then checks that the next ticks follow the new divisor counted from the write edge, with no extra tick from the old count. The bench also starts a mid-count reload well before a wrap and checks the same spacing.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

   typedef enum logic [2:0] {
      OFS_DATA  = 3'd0,
      OFS_IEN   = 3'd1,
      OFS_IDENT = 3'd2,
      OFS_LCTL  = 3'd3,
      OFS_MCTL  = 3'd4,
      OFS_LSTAT = 3'd5,
      OFS_MSTAT = 3'd6,
      OFS_SCR   = 3'd7
   } reg_ofs_e;

   localparam int BANK_BIT = 7;

   typedef struct packed {
      logic lcr_we;
      logic ier_we;
      logic dlo_we;
      logic dhi_we;
      logic tx_load;
      logic rx_take;
      logic stat_take;
   } dec_strobe_t;

endpackage

// File: rtl/serial_reg_decode.sv
module serial_reg_decode
   import serial_regbank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int IER_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              bank_sel,
   input  logic [DATA_W-1:0] lcr_val,
   input  logic [IER_W-1:0]  ier_val,
   input  logic [DATA_W-1:0] div_lo,
   input  logic [DATA_W-1:0] div_hi,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] line_stat,
   output dec_strobe_t       strb,
   output logic [DATA_W-1:0] rdata
);

   reg_ofs_e          ofs;
   logic [DATA_W-1:0] ier_ext;

   assign ofs     = reg_ofs_e'(addr);
   assign ier_ext = DATA_W'(ier_val);

   always_comb begin
      strb  = '0;
      rdata = '0;
      case (ofs)
         OFS_DATA: begin
            if (bank_sel) begin
               strb.dlo_we = wr_en;
               rdata       = div_lo;
            end else begin
               strb.tx_load = wr_en;
               strb.rx_take = rd_en;
               rdata        = rx_byte;
            end
         end
         OFS_IEN: begin
            if (bank_sel) begin
               strb.dhi_we = wr_en;
               rdata       = div_hi;
            end else begin
               strb.ier_we = wr_en;
               rdata       = ier_ext;
            end
         end
         OFS_LCTL: begin
            strb.lcr_we = wr_en;
            rdata       = lcr_val;
         end
         OFS_LSTAT: begin
            strb.stat_take = rd_en;
            rdata          = line_stat;
         end
         default: begin
            rdata = '0;
         end
      endcase
   end

   // R5
   bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_sel |-> !(strb.tx_load || strb.rx_take));

   // R10
   unused_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr == ADDR_W'(0) || addr == ADDR_W'(1) || addr == ADDR_W'(3))
      |-> !(strb.lcr_we || strb.ier_we || strb.dlo_we || strb.dhi_we));

endmodule

// File: rtl/serial_reg_store.sv
module serial_reg_store
   import serial_regbank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IER_W  = 4,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dec_strobe_t       strb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] lcr_q,
   output logic [IER_W-1:0]  ier_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              div_load,
   output logic [DIV_W-1:0]  div_next
);

   localparam int HI_W = DIV_W - DATA_W;

   always_comb begin
      div_next = div_q;
      if (strb.dlo_we) div_next[DATA_W-1:0] = wdata;
      if (strb.dhi_we) div_next[DIV_W-1:DATA_W] = wdata[HI_W-1:0];
   end

   assign div_load = strb.dlo_we | strb.dhi_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         ier_q <= '0;
         div_q <= '0;
      end else begin
         if (strb.lcr_we) lcr_q <= wdata;
         if (strb.ier_we) ier_q <= wdata[IER_W-1:0];
         if (div_load)    div_q <= div_next;
      end
   end

   // R2
   lcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.lcr_we |=> $stable(lcr_q));

   // R4
   ier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.ier_we |=> $stable(ier_q));

   // R5
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(strb.dlo_we || strb.dhi_we) |=> $stable(div_q));

endmodule

// File: rtl/serial_baud_tick.sv
module serial_baud_tick #(
   parameter int DIV_W    = 16,
   parameter bit TICK_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             load,
   input  logic [DIV_W-1:0] load_val,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (divisor != '0) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= (load_val == '0) ? '0 : load_val - DIV_W'(1);
      end else if (divisor == '0) begin
         cnt <= '0;
      end else if (cnt == '0) begin
         cnt <= divisor - DIV_W'(1);
      end else begin
         cnt <= cnt - DIV_W'(1);
      end
   end

   generate
      if (TICK_REG) begin : g_tick_flop
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= wrap;
         end
         assign tick = tick_q;
      end else begin : g_tick_comb
         assign tick = wrap;
      end
   endgenerate

   // R7
   tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && divisor > DIV_W'(1) && !load) |=> !wrap);

   // R9
   reload_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val > DIV_W'(1)) |=> !wrap);

endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
   import serial_regbank_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int IER_W    = 4,
   parameter int DIV_W    = 16,
   parameter bit TICK_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] line_stat,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_byte,
   output logic              rx_take,
   output logic              stat_take,
   output logic [DATA_W-1:0] line_ctrl,
   output logic [IER_W-1:0]  int_enable,
   output logic              baud_tick
);

   generate
      if (ADDR_W != 3) begin : g_bad_addr
         $error("serial_regbank: ADDR_W must be 3");
      end
      if (DIV_W != 2 * DATA_W) begin : g_bad_div
         $error("serial_regbank: DIV_W must be twice DATA_W");
      end
      if (IER_W < 1 || IER_W > DATA_W) begin : g_bad_ier
         $error("serial_regbank: IER_W out of range");
      end
      if (DATA_W <= BANK_BIT) begin : g_bad_data
         $error("serial_regbank: DATA_W too narrow for bank bit");
      end
   endgenerate

   dec_strobe_t       strb;
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_next;
   logic              div_load;

   serial_reg_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IER_W(IER_W)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .bank_sel (line_ctrl[BANK_BIT]),
      .lcr_val  (line_ctrl),
      .ier_val  (int_enable),
      .div_lo   (div_q[DATA_W-1:0]),
      .div_hi   (div_q[DIV_W-1:DATA_W]),
      .rx_byte  (rx_byte),
      .line_stat(line_stat),
      .strb     (strb),
      .rdata    (rdata)
   );

   serial_reg_store #(
      .DATA_W(DATA_W), .IER_W(IER_W), .DIV_W(DIV_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb    (strb),
      .wdata   (wdata),
      .lcr_q   (line_ctrl),
      .ier_q   (int_enable),
      .div_q   (div_q),
      .div_load(div_load),
      .div_next(div_next)
   );

   serial_baud_tick #(
      .DIV_W(DIV_W), .TICK_REG(TICK_REG)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (div_q),
      .load    (div_load),
      .load_val(div_next),
      .tick    (baud_tick)
   );

   assign tx_load   = strb.tx_load;
   assign tx_byte   = wdata;
   assign rx_take   = strb.rx_take;
   assign stat_take = strb.stat_take;

endmodule

// File: tb/serial_regbank_bench.sv
`timescale 1ns/1ps
module serial_regbank_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] rx_byte = 8'h00;
   logic [7:0] line_stat = 8'h00;
   logic       tx_load;
   logic [7:0] tx_byte;
   logic       rx_take;
   logic       stat_take;
   logic [7:0] line_ctrl;
   logic [3:0] int_enable;
   logic       baud_tick;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [7:0] cap_rdata;
   logic       cap_txl, cap_rxt, cap_stt, cap_tick;
   logic [7:0] cap_txb;

   always #2.5 clk = ~clk;

   serial_regbank u_serial_regbank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .line_stat(line_stat),
      .tx_load(tx_load), .tx_byte(tx_byte), .rx_take(rx_take),
      .stat_take(stat_take), .line_ctrl(line_ctrl), .int_enable(int_enable),
      .baud_tick(baud_tick)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_now(logic [2:0] a, logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      #1;
      cap_txl = tx_load; cap_txb = tx_byte; cap_tick = baud_tick;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic rd(logic [2:0] a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      cap_rdata = rdata; cap_rxt = rx_take; cap_stt = stat_take;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
   endtask

   // Called one sample after a divisor write edge (sample k = 0).
   task automatic watch_ticks(string req, int n, int span);
      int errs = 0;
      for (int k = 0; k < span; k++) begin
         bit exp_t = (k >= n - 1) && (((k - (n - 1)) % n) == 0);
         if (baud_tick !== exp_t) errs++;
         @(negedge clk); #1;
      end
      chk(req, errs, 0);
   endtask

   task automatic t_reset();
      rd(3'd3); chk("R1 lcr", cap_rdata, 8'h00);
      rd(3'd1); chk("R1 ier", cap_rdata, 8'h00);
      begin
         int seen = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (baud_tick) seen++;
         end
         chk("R1 no tick", seen, 0);
      end
      wr(3'd3, 8'h80);
      rd(3'd0); chk("R1 div lo", cap_rdata, 8'h00);
      rd(3'd1); chk("R1 div hi", cap_rdata, 8'h00);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_lcr();
      wr(3'd3, 8'h5B); rd(3'd3);
      chk("R2 readback", cap_rdata, 8'h5B);
      chk("R2 port", line_ctrl, 8'h5B);
      wr(3'd3, 8'h24); rd(3'd3);
      chk("R2 readback2", cap_rdata, 8'h24);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_data();
      wr(3'd0, 8'hC3);
      chk("R3 tx_load", cap_txl, 1'b1);
      chk("R3 tx_byte", cap_txb, 8'hC3);
      rx_byte = 8'h9E;
      rd(3'd0);
      chk("R3 rx data", cap_rdata, 8'h9E);
      chk("R3 rx_take", cap_rxt, 1'b1);
      rd(3'd3);
      chk("R3 no rx_take elsewhere", cap_rxt, 1'b0);
   endtask

   task automatic t_ier();
      wr(3'd1, 8'hFF); rd(3'd1);
      chk("R4 masked", cap_rdata, 8'h0F);
      wr(3'd1, 8'h05); rd(3'd1);
      chk("R4 value", cap_rdata, 8'h05);
      chk("R4 port", int_enable, 4'h5);
   endtask

   task automatic t_bank();
      wr(3'd3, 8'h83);
      wr(3'd0, 8'h34); chk("R5 no tx_load", cap_txl, 1'b0);
      wr(3'd1, 8'h12);
      rx_byte = 8'h77;
      rd(3'd0); chk("R5 div lo", cap_rdata, 8'h34);
      chk("R5 no rx_take", cap_rxt, 1'b0);
      rd(3'd1); chk("R5 div hi", cap_rdata, 8'h12);
      wr(3'd3, 8'h03);
      rd(3'd1); chk("R5 ier kept", cap_rdata, 8'h05);
      rd(3'd0); chk("R5 rx back", cap_rdata, 8'h77);
   endtask

   task automatic t_status();
      line_stat = 8'h61;
      wr(3'd5, 8'hFF);
      rd(3'd5);
      chk("R6 status", cap_rdata, 8'h61);
      chk("R6 stat_take", cap_stt, 1'b1);
      rd(3'd0); chk("R6 no stat_take", cap_stt, 1'b0);
   endtask

   task automatic t_unused();
      wr(3'd2, 8'hAA); wr(3'd4, 8'hAA); wr(3'd6, 8'hAA); wr(3'd7, 8'hAA);
      for (int a = 2; a < 8; a += 2) begin
         rd(3'(a)); chk("R10 zero", cap_rdata, 8'h00);
      end
      rd(3'd7); chk("R10 zero7", cap_rdata, 8'h00);
      rd(3'd3); chk("R10 lcr kept", cap_rdata, 8'h03);
      rd(3'd1); chk("R10 ier kept", cap_rdata, 8'h05);
   endtask

   task automatic set_div_measure(int n, string req);
      wr(3'd3, 8'h80);
      wr(3'd1, 8'(n >> 8));
      wr(3'd0, 8'(n));
      watch_ticks(req, n, 3 * n + 4);
   endtask

   task automatic t_rates();
      set_div_measure(1, "R7 div1");
      set_div_measure(2, "R7 div2");
      set_div_measure(6, "R7 div6");
      set_div_measure(12, "R9 div12");
      wr(3'd3, 8'h80);
      wr(3'd0, 8'h00);
      wr_now(3'd1, 8'h01);
      watch_ticks("R9 div256", 256, 600);
   endtask

   task automatic t_zero();
      wr(3'd3, 8'h80);
      wr(3'd1, 8'h00); wr(3'd0, 8'h00);
      begin
         int seen = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (baud_tick) seen++;
         end
         chk("R8 stopped", seen, 0);
      end
   endtask

   task automatic t_wrap_reload();
      wr(3'd3, 8'h80);
      wr(3'd1, 8'h00); wr(3'd0, 8'd6);
      // reload mid-count
      repeat (2) @(negedge clk);
      wr_now(3'd0, 8'd4);
      watch_ticks("R9 mid reload", 4, 14);
      // reload in the very cycle of a tick
      wr(3'd0, 8'd6);
      while (!baud_tick) begin @(negedge clk); #1; end
      wr_now(3'd0, 8'd3);
      chk("R9 tick in write cycle", cap_tick, 1'b1);
      watch_ticks("R9 wrap reload", 3, 10);
      wr(3'd3, 8'h00);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         vectors++; miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lcr();
      t_data();
      t_ier();
      t_bank();
      t_status();
      t_unused();
      t_rates();
      t_zero();
      t_wrap_reload();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule